// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block times the serial clock of an I2C controller in standard, fast and fast-plus modes. A 16-bit divider value sets the length of one time unit in system clock cycles. The speed selection decides how the SCL period is split. In standard mode the low and high phases are equal. In fast and fast-plus modes the low phase lasts twice as long as the high phase, which gives a one-third to two-thirds split. The block drives `scl_out`, where 1 means released and 0 means pulled low. It also pulses `phase_tick` at every boundary between phases, so a bit sequencer can step along with the clock.

The line is monitored through `scl_in`, which passes through a synchronizer of `SYNC_STAGES` flops. The high phase only counts down while the line is seen high, so a target that stretches the clock by holding SCL low simply lengthens that phase. Once the line is seen high, a programmable number of setup cycles is counted before the `data_ok` strobe fires. That strobe tells the sequencer when the data line may be handled.

A divider value of zero parks the block with SCL released and silent. The high-speed code is accepted but is timed exactly like standard mode.

Top module: `scl_baud_timer`

## Requirements
- R1: While and after reset (with divider 0), `scl_out` is 1, and `phase_tick` and `data_ok` are 0.
- R2: The low phase lasts exactly `baud_div` cycles when `speed_sel` is 0 (standard), and exactly 2×`baud_div` cycles when `speed_sel` is 1 (fast) or 2 (fast-plus).
- R3: `speed_sel` = 3 (high-speed code) gives the same low-phase length as standard mode: `baud_div` cycles.
- R4: For `baud_div` ≥ 4, the high phase ends (`scl_out` falls) exactly `baud_div` + `SYNC_STAGES` cycles after `scl_in` rises. Without stretching, `scl_in` rises together with `scl_out`.
- R5: While `scl_in` is held low after `scl_out` has been released, `scl_out` stays 1 and the high phase does not progress. The R4 timing then applies from the moment `scl_in` rises.
- R6: While `baud_div` ≠ 0, `phase_tick` is a one-cycle pulse. It is high in exactly those cycles in which `scl_out` differs from its value in the previous cycle.
- R7: When `setup_len` < `baud_div`, `data_ok` pulses for one cycle exactly once per high phase. Counting the cycles from the rise of `scl_in`, with the first cycle after the rise as cycle 1, the pulse falls in cycle `setup_len` + `SYNC_STAGES` + 2.
- R8: When `setup_len` ≥ `baud_div`, `data_ok` stays 0 for the whole high phase.
- R9: With `baud_div` = 0, the next cycle and all later ones have `scl_out` = 1, `phase_tick` = 0 and `data_ok` = 0, whatever `scl_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | BAUD_W | Cycles per time unit; 0 parks the timer |
| speed_sel | input | 2 | 0 standard, 1 fast, 2 fast-plus, 3 high-speed code (timed as standard) |
| setup_len | input | SETUP_W | Setup cycles counted after SCL is seen high |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_out | output | 1 | SCL drive: 1 released, 0 pulled low |
| phase_tick | output | 1 | One-cycle pulse at each SCL phase boundary |
| data_ok | output | 1 | One-cycle strobe once the setup count has elapsed in a high phase |

## Verification
All outputs are registered. A change on `scl_out` and its `phase_tick` appear in the same cycle, after the clock edge that ends the phase. An `scl_in` rise reaches the counters `SYNC_STAGES` edges later, which is why the high-phase length and the `data_ok` position are both measured from the rise of `scl_in` rather than from the rise of `scl_out`. The bench samples every cycle on the falling clock edge. It counts the samples in each low run and the samples with `scl_in` high in each high run, and records the index at which `data_ok` appears within that count. It compares these numbers with the formulas when each phase closes. A divider of zero takes effect one edge after it is applied, so the idle checks start only after that edge.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;

  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_FPLUS = 2'd2,
    SPD_HIGH  = 2'd3
  } spd_e;

  // Low phase spans two time units in the modes with the asymmetric split.
  function automatic logic low_is_double(input spd_e mode);
    return (mode == SPD_FAST) || (mode == SPD_FPLUS);
  endfunction

endpackage

// File: rtl/scl_sense_sync.sv
module scl_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_seen
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign line_seen = line_raw;
    end else begin : g_chain
      logic stage_q [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stg
        if (i == 0) begin : g_first
          always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= 1'b1;
            else     stage_q[0] <= line_raw;
          end
        end else begin : g_next
          always_ff @(posedge clk) begin
            if (rst) stage_q[i] <= 1'b1;
            else     stage_q[i] <= stage_q[i-1];
          end
        end
      end
      assign line_seen = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_phase_engine.sv
module scl_phase_engine #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [BAUD_W-1:0] unit_len,
  input  logic              low_double,
  input  logic              line_seen,
  output logic              phase_high,
  output logic              boundary
);

  localparam int CW = BAUD_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low_len;
  logic [CW-1:0] low_last;
  logic [CW-1:0] high_last;

  assign low_len   = low_double ? {unit_len, 1'b0} : {1'b0, unit_len};
  assign low_last  = low_len - CW'(1);
  assign high_last = {1'b0, unit_len} - CW'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_high <= 1'b1;
      cnt_q      <= '0;
      boundary   <= 1'b0;
    end else begin
      boundary <= 1'b0;
      if (!phase_high) begin
        if (cnt_q == low_last) begin
          phase_high <= 1'b1;
          cnt_q      <= '0;
          boundary   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (line_seen) begin
        // high phase advances only while the line is really high
        if (cnt_q == high_last) begin
          phase_high <= 1'b0;
          cnt_q      <= '0;
          boundary   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/scl_setup_strobe.sv
module scl_setup_strobe #(
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               phase_high,
  input  logic               line_seen,
  input  logic [SETUP_W-1:0] setup_len,
  output logic               strobe
);

  localparam int SW = SETUP_W + 1;

  logic [SW-1:0] seen_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || !phase_high) begin
      seen_cnt_q <= '0;
      strobe     <= 1'b0;
    end else begin
      strobe <= line_seen && (seen_cnt_q == {1'b0, setup_len});
      // saturate so a long high phase cannot wrap into a second strobe
      if (line_seen && (seen_cnt_q != '1))
        seen_cnt_q <= seen_cnt_q + SW'(1);
    end
  end

endmodule

// File: rtl/scl_baud_timer.sv
module scl_baud_timer
  import scl_timer_pkg::*;
#(
  parameter int BAUD_W      = 16,
  parameter int SETUP_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BAUD_W-1:0]  baud_div,
  input  logic [1:0]         speed_sel,
  input  logic [SETUP_W-1:0] setup_len,
  input  logic               scl_in,
  output logic               scl_out,
  output logic               phase_tick,
  output logic               data_ok
);

  logic run;
  logic low_double;
  logic line_seen;
  logic phase_high;

  assign run        = (baud_div != '0);
  assign low_double = low_is_double(spd_e'(speed_sel));

  scl_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .line_raw  (scl_in),
    .line_seen (line_seen)
  );

  scl_phase_engine #(.BAUD_W(BAUD_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .unit_len   (baud_div),
    .low_double (low_double),
    .line_seen  (line_seen),
    .phase_high (phase_high),
    .boundary   (phase_tick)
  );

  scl_setup_strobe #(.SETUP_W(SETUP_W)) u_setup (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .phase_high (phase_high),
    .line_seen  (line_seen),
    .setup_len  (setup_len),
    .strobe     (data_ok)
  );

  assign scl_out = phase_high;

endmodule

// File: rtl/scl_baud_timer_chk.sv
module scl_baud_timer_chk #(
  parameter int BAUD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [BAUD_W-1:0] baud_div,
  input logic              scl_out,
  input logic              phase_tick,
  input logic              data_ok
);

  // R6
  tick_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    phase_tick |-> (scl_out != $past(scl_out)));

  // R6
  edge_has_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(baud_div) != '0) && (scl_out != $past(scl_out))) |-> phase_tick);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (baud_div == '0) |=> (scl_out && !phase_tick && !data_ok));

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    data_ok |=> !data_ok);

  // R7
  strobe_in_high_chk: assert property (@(posedge clk) disable iff (rst)
    data_ok |-> $past(scl_out));

endmodule

bind scl_baud_timer scl_baud_timer_chk #(.BAUD_W(BAUD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .baud_div   (baud_div),
  .scl_out    (scl_out),
  .phase_tick (phase_tick),
  .data_ok    (data_ok)
);

// File: tb/test_scl_baud_timer.sv
`timescale 1ns/1ps
module test_scl_baud_timer;

  localparam int BAUD_W  = 16;
  localparam int SETUP_W = 8;
  localparam int SYNC    = 2;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [BAUD_W-1:0]  baud_div = '0;
  logic [1:0]         speed_sel = '0;
  logic [SETUP_W-1:0] setup_len = '0;
  logic               hold = 1'b0;
  logic               scl_in;
  logic               scl_out, phase_tick, data_ok;

  int checks = 0;
  int errors = 0;

  // wired-AND bus: target pulls low while hold is set
  assign scl_in = scl_out & ~hold;

  always #2.5 clk = ~clk;

  scl_baud_timer #(.BAUD_W(BAUD_W), .SETUP_W(SETUP_W), .SYNC_STAGES(SYNC)) i_scl_baud_timer (
    .clk(clk), .rst(rst), .baud_div(baud_div), .speed_sel(speed_sel),
    .setup_len(setup_len), .scl_in(scl_in), .scl_out(scl_out),
    .phase_tick(phase_tick), .data_ok(data_ok));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input int b, input int m);
    return (m == 1 || m == 2) ? 2 * b : b;
  endfunction

  // configuration seen by the monitor
  int  cur_baud, cur_mode, cur_setup;
  bit  mon_en = 1'b0;
  bit  prev_scl, seen_fall, hi_valid;
  int  hi_run, lo_run, dv_cnt, dv_idx;

  task automatic close_high();
    chk(hi_run == cur_baud + SYNC, "R4/R5 high length", hi_run, cur_baud + SYNC);
    if (cur_setup < cur_baud) begin
      chk(dv_cnt == 1, "R7 strobe count", dv_cnt, 1);
      chk(dv_idx == cur_setup + SYNC + 2, "R7 strobe position", dv_idx, cur_setup + SYNC + 2);
    end else begin
      chk(dv_cnt == 0, "R8 no strobe", dv_cnt, 0);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      chk(phase_tick == (scl_out != prev_scl), "R6 tick", phase_tick, scl_out != prev_scl);
      if (scl_out == 1'b0) begin
        if (prev_scl) begin
          if (data_ok) begin dv_cnt++; dv_idx = hi_run + 1; end
          if (hi_valid) close_high();
          seen_fall = 1'b1;
          lo_run = 1;
        end else begin
          lo_run++;
        end
      end else begin
        if (!prev_scl) begin
          if (seen_fall)
            chk(lo_run == exp_low(cur_baud, cur_mode), (cur_mode == 3) ? "R3 low length" : "R2 low length",
                lo_run, exp_low(cur_baud, cur_mode));
          hi_valid = seen_fall;
          hi_run = 0; dv_cnt = 0; dv_idx = 0;
        end
        if (scl_in) hi_run++;
        if (data_ok) begin dv_cnt++; dv_idx = hi_run; end
      end
      prev_scl = scl_out;
    end
  end

  task automatic wait_scl(input logic lvl);
    do begin @(posedge clk); #1; end while (scl_out !== lvl);
  endtask

  task automatic run_cfg(input int b, input int m, input int s, input int smax, input int pairs);
    mon_en = 1'b0;
    hold = 1'b0;
    baud_div = '0;
    repeat (SYNC + 4) @(posedge clk);
    #1;
    baud_div = BAUD_W'(b); speed_sel = 2'(m); setup_len = SETUP_W'(s);
    cur_baud = b; cur_mode = m; cur_setup = s;
    prev_scl = 1'b1; seen_fall = 1'b0; hi_valid = 1'b0;
    hi_run = 0; lo_run = 0; dv_cnt = 0; dv_idx = 0;
    mon_en = 1'b1;
    for (int p = 0; p < pairs; p++) begin
      int n;
      wait_scl(1'b0);
      n = (smax > 0) ? int'($urandom_range(smax, 0)) : 0;
      hold = (n > 0);            // R5 stretch by the target
      wait_scl(1'b1);
      repeat (n) @(posedge clk);
      #1 hold = 1'b0;
    end
    wait_scl(1'b0);
    @(negedge clk);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd7321);
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(scl_out == 1'b1, "R1 reset scl", scl_out, 1);
    chk(phase_tick == 1'b0, "R1 reset tick", phase_tick, 0);
    chk(data_ok == 1'b0, "R1 reset strobe", data_ok, 0);

    // directed corners
    run_cfg(4, 0, 0, 0, 4);     // R2 shortest standard, strobe at first seen cycle
    run_cfg(4, 1, 3, 0, 4);     // R2 fast, R7 strobe on the closing edge
    run_cfg(7, 3, 7, 3, 4);     // R3 high-speed code, R8 setup equal to divider, R5
    run_cfg(5, 2, 10, 0, 3);    // R2 fast-plus, R8 setup beyond divider
    run_cfg(16, 1, 2, 8, 5);    // R5 stretched fast mode
    run_cfg(300, 0, 200, 0, 2); // R7 long phase, large setup

    // constrained random
    for (int k = 0; k < 14; k++) begin
      int b, m, s, smax;
      b = int'($urandom_range(40, 4));
      m = int'($urandom_range(3, 0));
      s = int'($urandom_range(b + 3, 0));
      smax = ($urandom_range(1, 0) == 1) ? int'($urandom_range(12, 1)) : 0;
      run_cfg(b, m, s, smax, 5);
    end

    // R9: divider forced to zero in mid low phase
    baud_div = 16'd9; speed_sel = 2'd1; setup_len = 8'd1;
    wait_scl(1'b0);
    baud_div = '0;
    @(posedge clk);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      chk(scl_out == 1'b1, "R9 idle scl", scl_out, 1);
      chk(phase_tick == 1'b0, "R9 idle tick", phase_tick, 0);
      chk(data_ok == 1'b0, "R9 idle strobe", data_ok, 0);
      hold = (c % 7) < 3;
    end
    hold = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule